// File: doc/BRIEF.md
# Low-Side Output Stage Diagnostic Controller

This block is the digital control for a set of identical open-drain low-side output stages (two by default). Each stage has its own active-low command pin. Driving the pin low switches the transistor on, and a pin that is released or floating reads high and leaves the stage off. The output therefore keeps the logic phase of its command. The block receives three comparator flags per stage that describe the voltage on the output pin. From these flags it confirms three faults: short to battery, short to ground and open load. Each confirmed fault is latched into a sticky status bit. A confirmed battery short also switches its stage off.

Each fault is evaluated only in the stage state where it makes sense. The battery short is checked while the stage is on, and only after a blanking time measured from switch-on. Ground short and open load are checked while the stage is off. Open-load diagnosis can be turned off per stage, and this also removes the diagnostic current request. The block also gates the transmit line of a serial line driver. After a hardware reset the transmit line is held at its idle level until the host sends a software-reset strobe.

No data flows through this block, so it has no valid/ready interface. Every pin is a plain level or a one-cycle strobe, sampled on the rising clock edge.

Top module: `lsd_ctrl`

## Requirements
- R1: `drv_on[i]` is a register fed from `stage_in_n[i]`. A low command (0) switches the stage on at the next clock edge. A high or floating command (1) keeps the stage off.
- R2: While `rst_n` is low, all of the following are cleared at once, without waiting for a clock edge: `drv_on`, all fault bits and the internal transmit enable. While the transmit enable is cleared, `tx_out` is 1.
- R3: A battery short is evaluated only while the stage is on, and only once it has been on for at least `BLANK_CYC` clock edges. The fault is confirmed when `cmp_hi[i]` is high for `FILT_LEN` consecutive evaluated edges. On that same edge `flt_scb[i]` sets and `drv_on[i]` goes low.
- R4: After a battery-short shutdown the stage stays off while its command is held on. It may switch on again only after one of two events: the command is seen off (1) for at least one edge and then reapplied, or `stat_clr[i]` is pulsed.
- R5: A ground short is evaluated only while the stage is off. `flt_scg[i]` sets when `cmp_lo[i]` is high for `FILT_LEN` consecutive edges.
- R6: Open load is evaluated only while the stage is off and `ol_dis[i]` is 0. `flt_ol[i]` sets when `cmp_ol[i]` is high for `FILT_LEN` consecutive edges.
- R7: While `ol_dis[i]` is 1, `flt_ol[i]` is cleared from the next edge on and cannot set, and `diag_cur_en[i]` is 0.
- R8: Any cycle in which a fault condition is low restarts that fault's consecutive count. A run of `FILT_LEN-1` edges, a one-edge gap, and another run of `FILT_LEN-1` edges confirms nothing.
- R9: Fault bits are sticky. A `stat_clr[i]` pulse clears the three bits of stage `i`. If a fault confirms on the same edge as the clear, the set wins. A fault whose condition persists past confirmation stays set.
- R10: `tx_out` is 1 until a `soft_rst` pulse has been sampled after reset. From the edge that samples the pulse until the next reset, `tx_out` equals `tx_in`.
- R11: `diag_cur_en[i]` is 1 exactly when the stage is off and `ol_dis[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stage_in_n | input | N_STAGE | Per-stage command, 0 = on, 1 or floating = off |
| ol_dis | input | N_STAGE | Per-stage open-load diagnosis disable |
| cmp_hi | input | N_STAGE | Pin voltage above the battery-short threshold |
| cmp_lo | input | N_STAGE | Pin voltage below the ground-short threshold |
| cmp_ol | input | N_STAGE | Pin voltage inside the open-load window |
| stat_clr | input | N_STAGE | Per-stage read-clear strobe for the fault bits |
| soft_rst | input | 1 | Software-reset strobe that opens the transmit gate |
| tx_in | input | 1 | Transmit data from the host |
| drv_on | output | N_STAGE | Transistor gate enable per stage |
| diag_cur_en | output | N_STAGE | Open-load diagnostic current request |
| flt_scb | output | N_STAGE | Sticky battery-short fault |
| flt_scg | output | N_STAGE | Sticky ground-short fault |
| flt_ol | output | N_STAGE | Sticky open-load fault |
| tx_out | output | 1 | Gated transmit data to the line driver |

## Verification
Some properties are checked by assertions on every cycle. A stage commanded off is never driven. A battery-short bit never rises while the stage was off, and the stage is already off on the cycle it rises. A ground-short bit never rises while the stage was on. Open load never shows after a cycle with diagnosis disabled, and the diagnostic current is never requested while a stage is driven.

Other behaviour depends on exact timing and sequence, and only the bench scenarios can show it. These are: the exact edge on which the battery short confirms, counted from switch-on through the blanking time and the filter; the restart of the filter after a one-cycle gap; the re-arm only after the command is released; the clear that loses to a persisting fault; and the transmit gate staying closed until the software strobe. The behavioural model in the bench checks all of these on every clock.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Fault kinds handled by the per-stage filter bank; order sets the filter index.
  typedef enum logic [1:0] {
    FK_SCB = 2'd0,
    FK_SCG = 2'd1,
    FK_OL  = 2'd2
  } lsd_fault_e;

  localparam int unsigned LSD_N_FAULT = 3;

  typedef struct packed {
    logic scb;
    logic scg;
    logic ol;
  } lsd_flt_t;

endpackage

// File: rtl/lsd_filter.sv
// Consecutive-sample qualifier: confirm pulses on the edge where the
// condition has been high for LEN consecutive edges, and on every later
// edge while it stays high.
module lsd_filter #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic confirm
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] TOP = CW'(LEN - 1);

  logic [CW-1:0] run_q;

  assign confirm = cond && (run_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!cond) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + CW'(1);
    end
  end
endmodule

// File: rtl/lsd_stage.sv
module lsd_stage
  import lsd_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 16,
  parameter int unsigned BLANK_CYC = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_on,
  input  logic     ol_dis,
  input  logic     cmp_hi,
  input  logic     cmp_lo,
  input  logic     cmp_ol,
  input  logic     clr,
  output logic     drv_q,
  output logic     diag_en,
  output lsd_flt_t flt
);
  localparam int unsigned AW = $clog2(BLANK_CYC + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(BLANK_CYC);

  logic [AW-1:0] age_q;
  logic          blank_done;
  logic          shut_q, shut_d;
  logic [LSD_N_FAULT-1:0] cond, hit;
  lsd_flt_t      flt_q;

  assign blank_done = drv_q && (age_q == AGE_MAX);

  // Each fault is evaluated only in the output state where it is meaningful.
  assign cond[FK_SCB] = blank_done && cmp_hi;
  assign cond[FK_SCG] = !drv_q && cmp_lo;
  assign cond[FK_OL]  = !drv_q && !ol_dis && cmp_ol;

  for (genvar k = 0; k < LSD_N_FAULT; k++) begin : g_filt
    lsd_filter #(.LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (cond[k]),
      .confirm (hit[k])
    );
  end

  // Shutdown latch: set by a confirmed battery short, released when the
  // command is dropped or the host clears the stage status.
  assign shut_d = hit[FK_SCB] || (shut_q && cmd_on && !clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
      drv_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      shut_q <= shut_d;
      drv_q  <= cmd_on && !shut_d;
      if (!drv_q)
        age_q <= '0;
      else if (age_q != AGE_MAX)
        age_q <= age_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= '0;
    end else begin
      flt_q.scb <= hit[FK_SCB] || (flt_q.scb && !clr);
      flt_q.scg <= hit[FK_SCG] || (flt_q.scg && !clr);
      flt_q.ol  <= !ol_dis && (hit[FK_OL] || (flt_q.ol && !clr));
    end
  end

  assign flt     = flt_q;
  assign diag_en = !drv_q && !ol_dis;
endmodule

// File: rtl/lsd_tx_gate.sv
module lsd_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tx_in,
  output logic tx_out
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      open_q <= 1'b0;
    else if (soft_rst)
      open_q <= 1'b1;
  end

  // A closed gate holds the line at its recessive (idle high) level.
  assign tx_out = open_q ? tx_in : 1'b1;
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int unsigned N_STAGE   = 2,
  parameter int unsigned FILT_LEN  = 16,
  parameter int unsigned BLANK_CYC = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_STAGE-1:0] stage_in_n,
  input  logic [N_STAGE-1:0] ol_dis,
  input  logic [N_STAGE-1:0] cmp_hi,
  input  logic [N_STAGE-1:0] cmp_lo,
  input  logic [N_STAGE-1:0] cmp_ol,
  input  logic [N_STAGE-1:0] stat_clr,
  input  logic               soft_rst,
  input  logic               tx_in,
  output logic [N_STAGE-1:0] drv_on,
  output logic [N_STAGE-1:0] diag_cur_en,
  output logic [N_STAGE-1:0] flt_scb,
  output logic [N_STAGE-1:0] flt_scg,
  output logic [N_STAGE-1:0] flt_ol,
  output logic               tx_out
);
  lsd_flt_t flt_v [N_STAGE];

  for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
    lsd_stage #(
      .FILT_LEN  (FILT_LEN),
      .BLANK_CYC (BLANK_CYC)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_on  (!stage_in_n[i]),
      .ol_dis  (ol_dis[i]),
      .cmp_hi  (cmp_hi[i]),
      .cmp_lo  (cmp_lo[i]),
      .cmp_ol  (cmp_ol[i]),
      .clr     (stat_clr[i]),
      .drv_q   (drv_on[i]),
      .diag_en (diag_cur_en[i]),
      .flt     (flt_v[i])
    );
    assign flt_scb[i] = flt_v[i].scb;
    assign flt_scg[i] = flt_v[i].scg;
    assign flt_ol[i]  = flt_v[i].ol;
  end

  lsd_tx_gate u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .tx_in    (tx_in),
    .tx_out   (tx_out)
  );
endmodule

// File: rtl/lsd_ctrl_chk.sv
module lsd_ctrl_chk #(
  parameter int unsigned N_STAGE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_STAGE-1:0] stage_in_n,
  input logic [N_STAGE-1:0] ol_dis,
  input logic [N_STAGE-1:0] drv_on,
  input logic [N_STAGE-1:0] diag_cur_en,
  input logic [N_STAGE-1:0] flt_scb,
  input logic [N_STAGE-1:0] flt_scg,
  input logic [N_STAGE-1:0] flt_ol,
  input logic               tx_out
);
  // R2: reset forces outputs off and the transmit line idle
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r2_reset_quiet: assert (drv_on == '0 && flt_scb == '0 && flt_scg == '0
                                && flt_ol == '0 && tx_out == 1'b1)
        else $error("reset state violated");
    end
  end

  // R1: a stage commanded off is not driven on the following cycle
  a_r1_off_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_on & $past(stage_in_n)) == '0);

  // R3: a battery short rises only after a cycle in which the stage was on
  a_r3_scb_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_scb & ~$past(flt_scb) & ~$past(drv_on)) == '0);

  // R3: the stage is already off on the cycle its battery short appears
  a_r3_scb_shuts_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_scb & ~$past(flt_scb) & drv_on) == '0);

  // R5: a ground short rises only after a cycle in which the stage was off
  a_r5_scg_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_scg & ~$past(flt_scg) & $past(drv_on)) == '0);

  // R7: open load is never shown after a cycle with diagnosis disabled
  a_r7_ol_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_ol & $past(ol_dis)) == '0);

  // R11: no diagnostic current while the stage is driven
  a_r11_no_diag_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_cur_en & drv_on) == '0);
endmodule

bind lsd_ctrl lsd_ctrl_chk #(.N_STAGE(N_STAGE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stage_in_n  (stage_in_n),
  .ol_dis      (ol_dis),
  .drv_on      (drv_on),
  .diag_cur_en (diag_cur_en),
  .flt_scb     (flt_scb),
  .flt_scg     (flt_scg),
  .flt_ol      (flt_ol),
  .tx_out      (tx_out)
);

// File: tb/lsd_ctrl_test.sv
`timescale 1ns/1ps
module lsd_ctrl_test;
  localparam int N = 2;
  localparam int FL = 16;
  localparam int BL = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] stage_in_n = '1, ol_dis = '0, cmp_hi = '0, cmp_lo = '0, cmp_ol = '0, stat_clr = '0;
  logic soft_rst = 1'b0, tx_in = 1'b1;
  logic [N-1:0] drv_on, diag_cur_en, flt_scb, flt_scg, flt_ol;
  logic tx_out;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsd_ctrl #(.N_STAGE(N), .FILT_LEN(FL), .BLANK_CYC(BL)) uut (
    .clk(clk), .rst_n(rst_n), .stage_in_n(stage_in_n), .ol_dis(ol_dis),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .cmp_ol(cmp_ol), .stat_clr(stat_clr),
    .soft_rst(soft_rst), .tx_in(tx_in), .drv_on(drv_on), .diag_cur_en(diag_cur_en),
    .flt_scb(flt_scb), .flt_scg(flt_scg), .flt_ol(flt_ol), .tx_out(tx_out));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference model, updated on every rising edge
  int  m_age[N], m_rs[N], m_rg[N], m_ro[N];
  bit  m_drv[N], m_shut[N], m_fs[N], m_fg[N], m_fo[N], m_tx;
  bit  cmp_en = 0;

  always @(posedge clk) begin
    bit cmd, cs, cg, co, hs, hg, ho, nshut;
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_age[i] = 0; m_rs[i] = 0; m_rg[i] = 0; m_ro[i] = 0;
        m_drv[i] = 0; m_shut[i] = 0; m_fs[i] = 0; m_fg[i] = 0; m_fo[i] = 0;
      end else begin
        cmd = !stage_in_n[i];
        cs = m_drv[i] && m_age[i] >= BL && cmp_hi[i];
        cg = !m_drv[i] && cmp_lo[i];
        co = !m_drv[i] && !ol_dis[i] && cmp_ol[i];
        hs = cs && m_rs[i] >= FL - 1;
        hg = cg && m_rg[i] >= FL - 1;
        ho = co && m_ro[i] >= FL - 1;
        m_rs[i] = cs ? m_rs[i] + 1 : 0;
        m_rg[i] = cg ? m_rg[i] + 1 : 0;
        m_ro[i] = co ? m_ro[i] + 1 : 0;
        m_age[i] = m_drv[i] ? m_age[i] + 1 : 0;
        nshut = hs || (m_shut[i] && cmd && !stat_clr[i]);
        m_shut[i] = nshut;
        m_drv[i] = cmd && !nshut;
        m_fs[i] = hs || (m_fs[i] && !stat_clr[i]);
        m_fg[i] = hg || (m_fg[i] && !stat_clr[i]);
        m_fo[i] = !ol_dis[i] && (ho || (m_fo[i] && !stat_clr[i]));
      end
    end
    m_tx = rst_n && (m_tx || soft_rst);
    #1;
    if (cmp_en) begin
      for (int i = 0; i < N; i++) begin
        chk("R1 drv_on", drv_on[i], m_drv[i]);
        chk("R3 flt_scb", flt_scb[i], m_fs[i]);
        chk("R5 flt_scg", flt_scg[i], m_fg[i]);
        chk("R6 flt_ol", flt_ol[i], m_fo[i]);
        chk("R11 diag_cur_en", diag_cur_en[i], !m_drv[i] && !ol_dis[i]);
      end
      chk("R10 tx_out", tx_out, m_tx ? tx_in : 1'b1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    // R2: reset state
    chk("R2 drv_on in reset", drv_on, 0);
    chk("R2 faults in reset", {flt_scb, flt_scg, flt_ol}, 0);
    chk("R2 tx_out in reset", tx_out, 1);
    rst_n = 1'b1;
    cmp_en = 1;
    step(2);

    // R10: gate closed before the software strobe
    tx_in = 1'b0; step(3);
    chk("R10 tx held idle", tx_out, 1);
    soft_rst = 1'b1; step(1); soft_rst = 1'b0; step(1);
    chk("R10 tx follows after strobe", tx_out, 0);
    tx_in = 1'b1;

    // R1: command low switches on one edge later
    stage_in_n[1] = 1'b0; step(1);
    chk("R1 stage1 on", drv_on[1], 1);
    stage_in_n[1] = 1'b1; step(1);
    chk("R1 stage1 off", drv_on[1], 0);

    // R3: battery-short flag with stage off is ignored
    cmp_hi[1] = 1'b1; step(BL + FL + 5);
    chk("R3 scb ignored while off", flt_scb[1], 0);
    cmp_hi[1] = 1'b0;

    // R3: exact confirmation edge after blanking and filtering
    stage_in_n[0] = 1'b0; cmp_hi[0] = 1'b1;
    step(BL + FL);
    chk("R3 not yet confirmed", flt_scb[0], 0);
    chk("R3 still driven", drv_on[0], 1);
    step(1);
    chk("R3 confirmed", flt_scb[0], 1);
    chk("R3 shut off", drv_on[0], 0);

    // R4: stays off while command held, re-arms on release and reapply
    cmp_hi[0] = 1'b0; step(5);
    chk("R4 held off", drv_on[0], 0);
    stage_in_n[0] = 1'b1; step(1);
    stage_in_n[0] = 1'b0; step(1);
    chk("R4 re-armed", drv_on[0], 1);

    // R5: ground short ignored while stage on
    cmp_lo[0] = 1'b1; step(FL + 4);
    chk("R5 scg ignored while on", flt_scg[0], 0);
    cmp_lo[0] = 1'b0;

    // R8: broken run restarts the filter (stage1 is off)
    cmp_lo[1] = 1'b1; step(FL - 1);
    cmp_lo[1] = 1'b0; step(1);
    cmp_lo[1] = 1'b1; step(FL - 1);
    chk("R8 no confirm after gap", flt_scg[1], 0);
    step(1);
    chk("R5 scg confirmed", flt_scg[1], 1);

    // R9: clear loses to persisting fault, then clears once gone
    stat_clr[1] = 1'b1; step(1); stat_clr[1] = 1'b0;
    chk("R9 set wins over clear", flt_scg[1], 1);
    cmp_lo[1] = 1'b0; stat_clr[1] = 1'b1; step(1); stat_clr[1] = 1'b0;
    chk("R9 cleared", flt_scg[1], 0);

    // R7 / R6: open load masked, then detected
    ol_dis[1] = 1'b1; cmp_ol[1] = 1'b1; step(FL + 4);
    chk("R7 ol suppressed", flt_ol[1], 0);
    chk("R7 no diag current", diag_cur_en[1], 0);
    ol_dis[1] = 1'b0; step(FL);
    chk("R6 ol confirmed", flt_ol[1], 1);
    ol_dis[1] = 1'b1; step(1);
    chk("R7 ol cleared by disable", flt_ol[1], 0);
    cmp_ol[1] = 1'b0; ol_dis[1] = 1'b0;

    // R2: reset mid-run clears everything and closes the gate
    tx_in = 1'b0;
    rst_n = 1'b0; #1;
    chk("R2 async drv clear", drv_on, 0);
    chk("R2 tx closed again", tx_out, 1);
    step(2); rst_n = 1'b1; step(3);
    chk("R2 tx stays closed", tx_out, 1);
    step(2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule